// File: doc/BRIEF.md
# Integer Multiply/Divide Unit with HI/LO Interlock

This unit sits next to a single-cycle integer ALU and executes the long-latency integer operations: signed and unsigned 32-bit and 64-bit multiply, signed and unsigned 32-bit and 64-bit divide, and signed and unsigned multiply-accumulate and multiply-subtract. Every result lands in a HI/LO register pair. Each operation class has a fixed latency and a fixed repeat interval. The unit holds up only two things. An attempt to read HI or LO before the pending result has been written raises `read_stall`. A new multiply/divide offered before the repeat interval has elapsed raises `issue_stall`. Instructions that do not use the unit are never held.

An operation is accepted at the rising edge where `op_valid` is high and `issue_stall` is low. The cycle in which it was offered is called the issue cycle, c. For latency L, a read offered in cycle c+L is the first read that is not stalled, and the new HI/LO values appear on `hi_data`/`lo_data` in that same cycle. For repeat interval R, the next multiply/divide can be accepted in cycle c+R. All multiply-class operations have R = L-1, so the next operation is accepted on the same edge at which the previous result is written. A multiply-accumulate accepted on that edge takes the freshly written HI/LO as its source.

A strap pin, sampled only while reset is asserted, turns off fast multiply. With the strap set, every multiply-class latency and repeat interval grows by one cycle.

Top module: `hilo_muldiv`

The controller is a three-state machine:
- IDLE: nothing is pending.
- MULT: a multiply-class result is held, waiting to be written.
- DIV: a division is running.

Its transitions:
- IDLE→MULT and IDLE→DIV: on acceptance.
- MULT→IDLE and DIV→IDLE: on the write-back edge with no new acceptance.
- MULT→MULT and MULT→DIV: write-back and acceptance on the same edge.

The divider has its own three states:
- DV_IDLE, which moves to DV_RUN on start.
- DV_RUN, one quotient bit per cycle, which moves to DV_DONE after the last bit.
- DV_DONE, which holds the result and moves back to DV_RUN on the next start.

## Requirements
- R1: 32-bit multiply uses opcode 1 (signed) or 2 (unsigned) on the low words of A and B. It has latency 4 and repeat 3. The 64-bit product's upper word goes to HI and its lower word to LO, each sign-extended from bit 31.
- R2: 64-bit multiply uses opcode 3 (signed) or 4 (unsigned). It has latency 6 and repeat 5. The 128-bit product's upper 64 bits go to HI and its lower 64 bits to LO.
- R3: 32-bit divide uses opcode 5 (signed) or 6 (unsigned) and takes 36 cycles for both latency and repeat. The quotient, truncated toward zero, goes to LO. The remainder, which takes the sign of the dividend, goes to HI. Both are sign-extended from bit 31.
- R4: 64-bit divide uses opcode 7 (signed) or 8 (unsigned) and takes 68 cycles for both latency and repeat. The quotient goes to LO and the remainder to HI.
- R5: Multiply-accumulate uses opcode 9 (signed) or 10 (unsigned) with latency 3 and repeat 2. It adds the 32-bit product to {HI[31:0],LO[31:0]} and writes the sum back as in R1.
- R6: Multiply-subtract uses opcode 11 (signed) or 12 (unsigned) with latency 4 and repeat 3. It subtracts the product from {HI[31:0],LO[31:0]}.
- R7: If the strap is high during reset, every multiply-class latency and repeat grows by one cycle and divides are unchanged. A strap change after reset has no effect.
- R8: `read_stall` is high exactly when `rd_hi` or `rd_lo` is high while a result is pending. A valid opcode 0 or 15 never raises `issue_stall`.
- R9: A multiply/divide offered before its repeat interval has elapsed raises `issue_stall` and is accepted in the first cycle the interval allows.
- R10: Opcode 13 writes A to HI and opcode 14 writes A to LO, visible the next cycle. Either one is stalled while any result is pending.
- R11: A divide by zero takes the normal time and raises no exception. It yields LO = all ones and HI = the dividend; for the 32-bit forms the dividend is the low word, sign-extended.
- R12: After reset, HI and LO are zero and neither stall output is high.
- R13: An operation accepted on the edge at which the previous result is written sees the new HI/LO value as its accumulate source.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset (clears HI/LO; samples the strap) |
| slow_mul_strap | input | 1 | Fast-multiply disable, sampled during reset |
| op_valid | input | 1 | Opcode presented this cycle |
| op_code | input | 4 | Operation select (see requirements) |
| op_a | input | 64 | First operand / HI-LO write data |
| op_b | input | 64 | Second operand |
| rd_hi | input | 1 | A read of HI is attempted this cycle |
| rd_lo | input | 1 | A read of LO is attempted this cycle |
| issue_stall | output | 1 | Offered operation cannot be accepted this cycle |
| read_stall | output | 1 | HI/LO read must wait for a pending result |
| hi_data | output | 64 | Current HI contents |
| lo_data | output | 64 | Current LO contents |

## Verification
For an operation offered in cycle c, the HI/LO update and the release of `read_stall` are both due in cycle c+L. The next multiply/divide is due to be accepted in cycle c+R. Every other result is due one cycle after its write.

The bench keeps a countdown model of pending latency and repeat time. It compares both stall outputs and both data outputs against that model in every cycle, a fixed delay after the falling edge, so each output is read well after the edge that changed it. Separate counters then measure L and R for each operation class by offering a second operation and a polling read until each is released. These measurements run in both strap settings.

// File: rtl/mdu_pkg.sv
package mdu_pkg;

    localparam int XLEN = 64;
    localparam int HLEN = 32;

    typedef enum logic [3:0] {
        OP_NONE  = 4'd0,
        OP_MULS  = 4'd1,
        OP_MULU  = 4'd2,
        OP_DMULS = 4'd3,
        OP_DMULU = 4'd4,
        OP_DIVS  = 4'd5,
        OP_DIVU  = 4'd6,
        OP_DDIVS = 4'd7,
        OP_DDIVU = 4'd8,
        OP_MACS  = 4'd9,
        OP_MACU  = 4'd10,
        OP_MSBS  = 4'd11,
        OP_MSBU  = 4'd12,
        OP_WRHI  = 4'd13,
        OP_WRLO  = 4'd14,
        OP_SKIP  = 4'd15
    } mdu_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_MULT = 2'd1,
        ST_DIV  = 2'd2
    } ctl_st_e;

    typedef enum logic [1:0] {
        DV_IDLE = 2'd0,
        DV_RUN  = 2'd1,
        DV_DONE = 2'd2
    } div_st_e;

    function automatic logic [XLEN-1:0] sext_half(input logic [HLEN-1:0] v);
        return {{(XLEN-HLEN){v[HLEN-1]}}, v};
    endfunction

    function automatic logic op_is_arith(input mdu_op_e op);
        return (op >= OP_MULS) && (op <= OP_MSBU);
    endfunction

    function automatic logic op_is_div(input mdu_op_e op);
        return (op >= OP_DIVS) && (op <= OP_DDIVU);
    endfunction

    function automatic logic op_is_write(input mdu_op_e op);
        return (op == OP_WRHI) || (op == OP_WRLO);
    endfunction

endpackage

// File: rtl/mdu_ctrl.sv
module mdu_ctrl
    import mdu_pkg::*;
#(
    parameter int LAT_MUL  = 4,
    parameter int REP_MUL  = 3,
    parameter int LAT_DMUL = 6,
    parameter int REP_DMUL = 5,
    parameter int LAT_DIV  = 36,
    parameter int LAT_DDIV = 68,
    parameter int LAT_MAC  = 3,
    parameter int REP_MAC  = 2,
    parameter int LAT_MSB  = 4,
    parameter int REP_MSB  = 3
) (
    input  logic    clk,
    input  logic    rst_n,
    input  logic    strap,
    input  logic    valid,
    input  mdu_op_e op,
    input  logic    rd_req,
    output logic    issue_stall,
    output logic    read_stall,
    output logic    acc_arith,
    output logic    acc_write,
    output logic    commit,
    output logic    commit_div
);

    localparam int CW = $clog2(LAT_DDIV + 2);

    ctl_st_e        state_q, state_d;
    logic [CW-1:0]  lat_q, rep_q;
    logic [CW-1:0]  lat_ld, rep_ld;
    logic           slow_q;
    logic           mul_class;
    int             lat_b, rep_b;

    // strap captured only while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) slow_q <= strap;
    end

    // per-opcode timing
    always_comb begin
        lat_b     = 1;
        rep_b     = 1;
        mul_class = 1'b0;
        unique case (op)
            OP_MULS, OP_MULU:   begin lat_b = LAT_MUL;  rep_b = REP_MUL;  mul_class = 1'b1; end
            OP_DMULS, OP_DMULU: begin lat_b = LAT_DMUL; rep_b = REP_DMUL; mul_class = 1'b1; end
            OP_DIVS, OP_DIVU:   begin lat_b = LAT_DIV;  rep_b = LAT_DIV;  end
            OP_DDIVS, OP_DDIVU: begin lat_b = LAT_DDIV; rep_b = LAT_DDIV; end
            OP_MACS, OP_MACU:   begin lat_b = LAT_MAC;  rep_b = REP_MAC;  mul_class = 1'b1; end
            OP_MSBS, OP_MSBU:   begin lat_b = LAT_MSB;  rep_b = REP_MSB;  mul_class = 1'b1; end
            default:            begin lat_b = 1;        rep_b = 1;        end
        endcase
        lat_ld = CW'(lat_b + int'(mul_class & slow_q) - 1);
        rep_ld = CW'(rep_b + int'(mul_class & slow_q) - 1);
    end

    // outputs
    always_comb begin
        issue_stall = valid && ((op_is_arith(op) && (rep_q != '0)) ||
                                (op_is_write(op) && (lat_q != '0)));
        read_stall  = rd_req && (lat_q != '0);
        acc_arith   = valid && op_is_arith(op) && (rep_q == '0);
        acc_write   = valid && op_is_write(op) && (lat_q == '0);
        commit      = (lat_q == CW'(1));
        commit_div  = commit && (state_q == ST_DIV);
    end

    // next state
    always_comb begin
        state_d = state_q;
        if (acc_arith)   state_d = op_is_div(op) ? ST_DIV : ST_MULT;
        else if (commit) state_d = ST_IDLE;
    end

    // state register and countdowns
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            lat_q   <= '0;
            rep_q   <= '0;
        end else begin
            state_q <= state_d;
            if (acc_arith) begin
                lat_q <= lat_ld;
                rep_q <= rep_ld;
            end else begin
                if (lat_q != '0) lat_q <= lat_q - CW'(1);
                if (rep_q != '0) rep_q <= rep_q - CW'(1);
            end
        end
    end

    p_idle_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (lat_q == '0 && rep_q == '0));

    p_rep_within_lat_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rep_q <= lat_q);

    p_strap_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && $past(rst_n)) |-> $stable(slow_q));

    p_div_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DIV && lat_q > CW'(1)) |-> !acc_arith);

endmodule

// File: rtl/mdu_divider.sv
module mdu_divider
    import mdu_pkg::*;
#(
    parameter int STEPS_W = $clog2(XLEN + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start,
    input  logic            wide,
    input  logic            signed_op,
    input  logic [XLEN-1:0] num,
    input  logic [XLEN-1:0] den,
    output logic            done,
    output logic [XLEN-1:0] quo,
    output logic [XLEN-1:0] rem
);

    div_st_e             st_q, st_d;
    logic [XLEN:0]       rem_q;
    logic [XLEN-1:0]     quo_q, dvs_q, raw_q;
    logic [STEPS_W-1:0]  steps_q;
    logic                wide_q, negq_q, negr_q, zero_q;

    logic                sa, sb;
    logic [XLEN-1:0]     mag_a, mag_b;
    logic [XLEN:0]       trial;
    logic                fits;
    logic [HLEN-1:0]     q32, r32;

    always_comb begin
        sa = signed_op && (wide ? num[XLEN-1] : num[HLEN-1]);
        sb = signed_op && (wide ? den[XLEN-1] : den[HLEN-1]);
        if (wide) begin
            mag_a = sa ? (~num + 1'b1) : num;
            mag_b = sb ? (~den + 1'b1) : den;
        end else begin
            mag_a = {(sa ? (~num[HLEN-1:0] + 1'b1) : num[HLEN-1:0]), {HLEN{1'b0}}};
            mag_b = {{HLEN{1'b0}}, (sb ? (~den[HLEN-1:0] + 1'b1) : den[HLEN-1:0])};
        end
        trial = {rem_q[XLEN-1:0], quo_q[XLEN-1]};
        fits  = trial >= {1'b0, dvs_q};
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            DV_IDLE: if (start) st_d = DV_RUN;
            DV_RUN:  if (steps_q == STEPS_W'(1)) st_d = DV_DONE;
            DV_DONE: if (start) st_d = DV_RUN;
            default: st_d = DV_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= DV_IDLE;
            rem_q   <= '0;
            quo_q   <= '0;
            dvs_q   <= '0;
            raw_q   <= '0;
            steps_q <= '0;
            wide_q  <= 1'b0;
            negq_q  <= 1'b0;
            negr_q  <= 1'b0;
            zero_q  <= 1'b0;
        end else begin
            st_q <= st_d;
            if (start) begin
                rem_q   <= '0;
                quo_q   <= mag_a;
                dvs_q   <= mag_b;
                raw_q   <= num;
                steps_q <= wide ? STEPS_W'(XLEN) : STEPS_W'(HLEN);
                wide_q  <= wide;
                negq_q  <= sa ^ sb;
                negr_q  <= sa;
                zero_q  <= (mag_b == '0);
            end else if (st_q == DV_RUN) begin
                rem_q   <= fits ? (trial - {1'b0, dvs_q}) : trial;
                quo_q   <= {quo_q[XLEN-2:0], fits};
                steps_q <= steps_q - STEPS_W'(1);
            end
        end
    end

    // sign fix-up and divide-by-zero override
    always_comb begin
        done = (st_q == DV_DONE);
        q32  = negq_q ? (~quo_q[HLEN-1:0] + 1'b1) : quo_q[HLEN-1:0];
        r32  = negr_q ? (~rem_q[HLEN-1:0] + 1'b1) : rem_q[HLEN-1:0];
        if (zero_q) begin
            quo = '1;
            rem = wide_q ? raw_q : sext_half(raw_q[HLEN-1:0]);
        end else if (wide_q) begin
            quo = negq_q ? (~quo_q + 1'b1) : quo_q;
            rem = negr_q ? (~rem_q[XLEN-1:0] + 1'b1) : rem_q[XLEN-1:0];
        end else begin
            quo = sext_half(q32);
            rem = sext_half(r32);
        end
    end

    p_run_steps_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == DV_RUN) |-> (steps_q != '0));

endmodule

// File: rtl/mdu_multiplier.sv
module mdu_multiplier
    import mdu_pkg::*;
(
    input  mdu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    input  logic [XLEN-1:0] acc,
    output logic [XLEN-1:0] res_hi,
    output logic [XLEN-1:0] res_lo
);

    logic signed [XLEN-1:0]   sp32;
    logic [XLEN-1:0]          up32;
    logic signed [2*XLEN-1:0] sp64;
    logic [2*XLEN-1:0]        up64;
    logic [XLEN-1:0]          sum;

    always_comb begin
        sp32 = $signed({{HLEN{a[HLEN-1]}}, a[HLEN-1:0]}) *
               $signed({{HLEN{b[HLEN-1]}}, b[HLEN-1:0]});
        up32 = {{HLEN{1'b0}}, a[HLEN-1:0]} * {{HLEN{1'b0}}, b[HLEN-1:0]};
        sp64 = $signed({{XLEN{a[XLEN-1]}}, a}) * $signed({{XLEN{b[XLEN-1]}}, b});
        up64 = {{XLEN{1'b0}}, a} * {{XLEN{1'b0}}, b};
        sum  = '0;
        res_hi = '0;
        res_lo = '0;
        unique case (op)
            OP_MULS: begin
                res_hi = sext_half(sp32[XLEN-1:HLEN]);
                res_lo = sext_half(sp32[HLEN-1:0]);
            end
            OP_MULU: begin
                res_hi = sext_half(up32[XLEN-1:HLEN]);
                res_lo = sext_half(up32[HLEN-1:0]);
            end
            OP_DMULS: begin
                res_hi = sp64[2*XLEN-1:XLEN];
                res_lo = sp64[XLEN-1:0];
            end
            OP_DMULU: begin
                res_hi = up64[2*XLEN-1:XLEN];
                res_lo = up64[XLEN-1:0];
            end
            OP_MACS, OP_MACU, OP_MSBS, OP_MSBU: begin
                unique case (op)
                    OP_MACS: sum = acc + sp32;
                    OP_MACU: sum = acc + up32;
                    OP_MSBS: sum = acc - sp32;
                    default: sum = acc - up32;
                endcase
                res_hi = sext_half(sum[XLEN-1:HLEN]);
                res_lo = sext_half(sum[HLEN-1:0]);
            end
            default: begin
                res_hi = '0;
                res_lo = '0;
            end
        endcase
    end

endmodule

// File: rtl/hilo_muldiv.sv
module hilo_muldiv
    import mdu_pkg::*;
#(
    parameter int LAT_MUL  = 4,
    parameter int REP_MUL  = 3,
    parameter int LAT_DMUL = 6,
    parameter int REP_DMUL = 5,
    parameter int LAT_DIV  = 36,
    parameter int LAT_DDIV = 68,
    parameter int LAT_MAC  = 3,
    parameter int REP_MAC  = 2,
    parameter int LAT_MSB  = 4,
    parameter int REP_MSB  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        slow_mul_strap,
    input  logic        op_valid,
    input  logic [3:0]  op_code,
    input  logic [63:0] op_a,
    input  logic [63:0] op_b,
    input  logic        rd_hi,
    input  logic        rd_lo,
    output logic        issue_stall,
    output logic        read_stall,
    output logic [63:0] hi_data,
    output logic [63:0] lo_data
);

    mdu_op_e         op_e;
    logic            acc_arith, acc_write, commit, commit_div;
    logic            div_done;
    logic [XLEN-1:0] div_quo, div_rem;
    logic [XLEN-1:0] mul_hi, mul_lo;
    logic [XLEN-1:0] pend_hi, pend_lo;
    logic [XLEN-1:0] wb_hi, wb_lo, acc_src;
    logic [XLEN-1:0] hi_q, lo_q;

    assign op_e = mdu_op_e'(op_code);

    mdu_ctrl #(
        .LAT_MUL (LAT_MUL),  .REP_MUL (REP_MUL),
        .LAT_DMUL(LAT_DMUL), .REP_DMUL(REP_DMUL),
        .LAT_DIV (LAT_DIV),  .LAT_DDIV(LAT_DDIV),
        .LAT_MAC (LAT_MAC),  .REP_MAC (REP_MAC),
        .LAT_MSB (LAT_MSB),  .REP_MSB (REP_MSB)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .strap      (slow_mul_strap),
        .valid      (op_valid),
        .op         (op_e),
        .rd_req     (rd_hi | rd_lo),
        .issue_stall(issue_stall),
        .read_stall (read_stall),
        .acc_arith  (acc_arith),
        .acc_write  (acc_write),
        .commit     (commit),
        .commit_div (commit_div)
    );

    mdu_divider u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (acc_arith && op_is_div(op_e)),
        .wide     ((op_e == OP_DDIVS) || (op_e == OP_DDIVU)),
        .signed_op((op_e == OP_DIVS) || (op_e == OP_DDIVS)),
        .num      (op_a),
        .den      (op_b),
        .done     (div_done),
        .quo      (div_quo),
        .rem      (div_rem)
    );

    // write-back value and the accumulate source seen by a same-edge issue
    always_comb begin
        wb_hi   = commit_div ? div_rem : pend_hi;
        wb_lo   = commit_div ? div_quo : pend_lo;
        acc_src = commit ? {wb_hi[HLEN-1:0], wb_lo[HLEN-1:0]}
                         : {hi_q[HLEN-1:0],  lo_q[HLEN-1:0]};
    end

    mdu_multiplier u_mul (
        .op    (op_e),
        .a     (op_a),
        .b     (op_b),
        .acc   (acc_src),
        .res_hi(mul_hi),
        .res_lo(mul_lo)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_q    <= '0;
            lo_q    <= '0;
            pend_hi <= '0;
            pend_lo <= '0;
        end else begin
            if (commit) begin
                hi_q <= wb_hi;
                lo_q <= wb_lo;
            end
            if (acc_write) begin
                if (op_e == OP_WRHI) hi_q <= op_a;
                else                 lo_q <= op_a;
            end
            if (acc_arith && !op_is_div(op_e)) begin
                pend_hi <= mul_hi;
                pend_lo <= mul_lo;
            end
        end
    end

    assign hi_data = hi_q;
    assign lo_data = lo_q;

    p_div_ready_r4: assert property (@(posedge clk) disable iff (!rst_n)
        commit_div |-> div_done);

    p_hilo_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!commit && !acc_write) |=> ($stable(hi_data) && $stable(lo_data)));

    p_no_write_pending_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_write) |-> !read_stall);

endmodule

// File: tb/hilo_muldiv_test.sv
module hilo_muldiv_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        strap = 1'b0;
    logic        op_valid = 1'b0;
    logic [3:0]  op_code = 4'd0;
    logic [63:0] op_a = '0, op_b = '0;
    logic        rd_hi = 1'b0, rd_lo = 1'b0;
    logic        issue_stall, read_stall;
    logic [63:0] hi_data, lo_data;

    int checks = 0;
    int fails  = 0;
    string cur = "R12";

    // model state
    int          lat_m = 0, rep_m = 0;
    bit          slow_m = 0;
    logic [63:0] mhi = '0, mlo = '0, phi = '0, plo = '0;

    always #5 clk = ~clk;

    hilo_muldiv uut (
        .clk(clk), .rst_n(rst_n), .slow_mul_strap(strap),
        .op_valid(op_valid), .op_code(op_code), .op_a(op_a), .op_b(op_b),
        .rd_hi(rd_hi), .rd_lo(rd_lo),
        .issue_stall(issue_stall), .read_stall(read_stall),
        .hi_data(hi_data), .lo_data(lo_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    function automatic int lat_of(input logic [3:0] op, input bit slow);
        case (op)
            1, 2:   return 4 + int'(slow);
            3, 4:   return 6 + int'(slow);
            5, 6:   return 36;
            7, 8:   return 68;
            9, 10:  return 3 + int'(slow);
            default: return 4 + int'(slow);
        endcase
    endfunction

    function automatic int rep_of(input logic [3:0] op, input bit slow);
        case (op)
            1, 2:   return 3 + int'(slow);
            3, 4:   return 5 + int'(slow);
            5, 6:   return 36;
            7, 8:   return 68;
            9, 10:  return 2 + int'(slow);
            default: return 3 + int'(slow);
        endcase
    endfunction

    function automatic logic [63:0] sx(input logic [31:0] v);
        return {{32{v[31]}}, v};
    endfunction

    task automatic model_res(input logic [3:0] op, input logic [63:0] a, b, h0, l0,
                             output logic [63:0] rh, output logic [63:0] rl);
        longint          sa, sb, sq, sr, p;
        longint unsigned ua, ub, uq, ur;
        logic signed [127:0] w;
        logic [127:0]        u;
        logic [63:0]         accv, r;
        accv = {h0[31:0], l0[31:0]};
        rh = '0; rl = '0;
        case (op)
            1: begin sa = $signed(a[31:0]); sb = $signed(b[31:0]); p = sa * sb;
                     rh = sx(p[63:32]); rl = sx(p[31:0]); end
            2: begin ua = a[31:0]; ub = b[31:0]; ua = ua * ub;
                     rh = sx(ua[63:32]); rl = sx(ua[31:0]); end
            3: begin w = $signed(a) * $signed(b); rh = w[127:64]; rl = w[63:0]; end
            4: begin u = {64'd0, a} * {64'd0, b}; rh = u[127:64]; rl = u[63:0]; end
            5: begin sa = $signed(a[31:0]); sb = $signed(b[31:0]);
                     if (sb == 0) begin rl = '1; rh = sx(a[31:0]); end
                     else begin sq = sa / sb; sr = sa % sb; rl = sx(sq[31:0]); rh = sx(sr[31:0]); end end
            6: begin ua = a[31:0]; ub = b[31:0];
                     if (ub == 0) begin rl = '1; rh = sx(a[31:0]); end
                     else begin uq = ua / ub; ur = ua % ub; rl = sx(uq[31:0]); rh = sx(ur[31:0]); end end
            7: begin sa = a; sb = b;
                     if (sb == 0) begin rl = '1; rh = a; end
                     else begin sq = sa / sb; sr = sa % sb; rl = sq; rh = sr; end end
            8: begin ua = a; ub = b;
                     if (ub == 0) begin rl = '1; rh = a; end
                     else begin rl = ua / ub; rh = ua % ub; end end
            default: begin
                sa = $signed(a[31:0]); sb = $signed(b[31:0]); p = sa * sb;
                ua = a[31:0]; ub = b[31:0]; ua = ua * ub;
                case (op)
                    9:  r = accv + p;
                    10: r = accv + ua;
                    11: r = accv - p;
                    default: r = accv - ua;
                endcase
                rh = sx(r[63:32]); rl = sx(r[31:0]);
            end
        endcase
    endtask

    // one cycle: drive at the falling edge, check, advance the model past the rising edge
    task automatic step(input bit v, input logic [3:0] op, input logic [63:0] a, b,
                        input bit rh, input bit rl,
                        output bit acc, output bit is_a, output bit rs_a);
        bit arith, wr, e_is, e_rs;
        op_valid = v; op_code = op; op_a = a; op_b = b; rd_hi = rh; rd_lo = rl;
        #1;
        arith = (op >= 1) && (op <= 12);
        wr    = (op == 13) || (op == 14);
        e_is  = v && ((arith && rep_m != 0) || (wr && lat_m != 0));
        e_rs  = (rh || rl) && (lat_m != 0);
        chk({issue_stall, read_stall} == {e_is, e_rs}, cur, "stalls",
            {62'd0, issue_stall, read_stall}, {62'd0, e_is, e_rs});
        chk(hi_data === mhi, cur, "hi", hi_data, mhi);
        chk(lo_data === mlo, cur, "lo", lo_data, mlo);
        is_a = issue_stall; rs_a = read_stall;
        acc  = v && !e_is && (arith || wr);
        if (lat_m == 1) begin mhi = phi; mlo = plo; end
        if (lat_m > 0) lat_m--;
        if (rep_m > 0) rep_m--;
        if (acc && arith) begin
            model_res(op, a, b, mhi, mlo, phi, plo);
            lat_m = lat_of(op, slow_m) - 1;
            rep_m = rep_of(op, slow_m) - 1;
        end
        if (acc && wr) begin
            if (op == 13) mhi = a; else mlo = a;
        end
        @(negedge clk);
    endtask

    task automatic idle();
        bit x, y, z;
        step(0, 0, '0, '0, 0, 0, x, y, z);
    endtask

    task automatic drain();
        for (int i = 0; i < 100 && lat_m != 0; i++) idle();
        idle();
    endtask

    task automatic do_reset(input bit s);
        rst_n = 1'b0; strap = s;
        op_valid = 0; rd_hi = 0; rd_lo = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        lat_m = 0; rep_m = 0; slow_m = s;
        mhi = '0; mlo = '0; phi = '0; plo = '0;
    endtask

    // count repeat interval and latency of an operation class
    task automatic measure(input logic [3:0] op, input logic [63:0] a, b,
                           input int el, input int er, input string tag);
        bit acc, is_a, rs_a;
        int n;
        cur = tag;
        drain();
        step(1, op, a, b, 0, 0, acc, is_a, rs_a);
        n = 0;
        for (int i = 0; i < 200; i++) begin
            n++;
            step(1, op, b, a, 0, 0, acc, is_a, rs_a);
            if (!is_a) break;
        end
        chk(n == er, {tag, "/R9"}, "repeat cycles", 64'(n), 64'(er));
        n = 0;
        for (int i = 0; i < 200; i++) begin
            n++;
            step(0, 0, '0, '0, 0, 1, acc, is_a, rs_a);
            if (!rs_a) break;
        end
        chk(n == el, tag, "latency cycles", 64'(n), 64'(el));
        drain();
    endtask

    initial begin
        #2_000_000;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        bit acc, is_a, rs_a;
        logic [63:0] base, expv;
        @(negedge clk);
        do_reset(0);

        // R12: reset state
        cur = "R12";
        step(0, 0, '0, '0, 1, 1, acc, is_a, rs_a);
        chk(!rs_a && !is_a && hi_data == 0 && lo_data == 0, "R12", "reset",
            hi_data | lo_data, 64'd0);

        measure(1, -64'sd7, 64'd123456, 4, 3, "R1");
        measure(2, 64'h0000_0000_FFFF_FFFF, 64'd2, 4, 3, "R1");
        measure(3, -64'sd3, 64'h1_0000_0001, 6, 5, "R2");
        measure(4, '1, '1, 6, 5, "R2");
        measure(9, -64'sd5, 64'd6, 3, 2, "R5");
        measure(10, 64'hFFFF_FFFF, 64'd3, 3, 2, "R5");
        measure(11, 64'd9, -64'sd4, 4, 3, "R6");
        measure(12, 64'd100, 64'd7, 4, 3, "R6");
        measure(5, -64'sd100, 64'd7, 36, 36, "R3");
        measure(6, 64'h0000_0000_8000_0001, 64'd10, 36, 36, "R3");
        measure(7, -64'sd1000000000000, 64'd3, 68, 68, "R4");
        measure(8, 64'hF000_0000_0000_0001, 64'd12345, 68, 68, "R4");
        measure(5, -64'sd9, 64'd0, 36, 36, "R11");
        measure(8, 64'd5, 64'd0, 68, 68, "R11");

        // R10: write to HI held off while pending, then accepted
        cur = "R10";
        drain();
        step(1, 1, 64'd3, 64'd5, 0, 0, acc, is_a, rs_a);
        step(1, 13, 64'h123, '0, 0, 0, acc, is_a, rs_a);
        chk(is_a, "R10", "write stalled while pending", 64'(is_a), 64'd1);
        drain();
        step(1, 13, 64'hABC, '0, 0, 0, acc, is_a, rs_a);
        step(1, 14, 64'hDEF, '0, 0, 0, acc, is_a, rs_a);
        chk(hi_data == 64'hABC, "R10", "hi written", hi_data, 64'hABC);
        idle();
        chk(lo_data == 64'hDEF, "R10", "lo written", lo_data, 64'hDEF);

        // R8: non-unit opcodes never stall; reads stall only when requested
        cur = "R8";
        step(1, 6, 64'd50, 64'd7, 0, 0, acc, is_a, rs_a);
        step(1, 0, '0, '0, 0, 0, acc, is_a, rs_a);
        chk(!is_a && !rs_a, "R8", "opcode 0 during divide", 64'({is_a, rs_a}), 64'd0);
        step(1, 15, '0, '0, 0, 0, acc, is_a, rs_a);
        chk(!is_a, "R8", "opcode 15 during divide", 64'(is_a), 64'd0);
        step(0, 0, '0, '0, 1, 0, acc, is_a, rs_a);
        chk(rs_a, "R8", "hi read during divide", 64'(rs_a), 64'd1);
        drain();

        // R13: back-to-back accumulate picks up the just-written result
        cur = "R13";
        base = {hi_data[31:0], lo_data[31:0]};
        step(1, 9, 64'd2, 64'd3, 0, 0, acc, is_a, rs_a);
        for (int i = 0; i < 10; i++) begin
            step(1, 9, 64'd4, 64'd5, 0, 0, acc, is_a, rs_a);
            if (acc) break;
        end
        drain();
        expv = base + 64'd26;
        chk({hi_data[31:0], lo_data[31:0]} == expv, "R13", "chained accumulate",
            {hi_data[31:0], lo_data[31:0]}, expv);

        // R7: strap change after reset is ignored
        strap = 1'b1;
        measure(1, 64'd11, 64'd13, 4, 3, "R7");

        // R7: strap held during reset slows multiply class only
        do_reset(1);
        measure(1, 64'd11, 64'd13, 5, 4, "R7");
        measure(4, 64'd17, 64'd19, 7, 6, "R7");
        measure(10, 64'd2, 64'd9, 4, 3, "R7");
        measure(12, 64'd2, 64'd9, 5, 4, "R7");
        measure(6, 64'd1000, 64'd33, 36, 36, "R7");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule